// File: doc/BRIEF.md
# Descriptor Ring Queue Controller

This block runs a single hardware command queue of a memory-to-memory copy engine. Software places fixed-size 32-byte descriptors in a circular ring in system memory, programs the ring's base address and its length (in descriptors), and then moves a write index forward to hand work to the hardware. The controller compares its own read index with that write index. For each pending slot it issues a memory read request for the descriptor and passes the returned descriptor to a downstream copy/validation stage. When that stage reports an error code, the controller writes a completion status word back into the descriptor in memory. It then advances the read index, wrapping it at the ring length, and flags a completion interrupt.

Software sees progress by polling the read index in the queue's register window. The window is 32 bytes wide, and queue number `QUEUE_ID` decodes at byte offset `(QUEUE_ID+1)*0x20` of the register space. The interrupt output is a level signal that follows a sticky status bit, and software clears that bit by writing it back as zero. The controller handles one descriptor at a time.

Top module: `ring_queue_ctrl`

## Requirements
- R1: After reset, every window register reads back as zero, and `irq`, `fetch_valid`, `exec_valid` and `wb_valid` are low.
- R2: The block decodes a register access only when `reg_addr` falls inside its own 32-byte window at `(QUEUE_ID+1)*0x20`. Writes outside that window change nothing, and reads outside it return zero. Within the window the offsets are: 0x08 ring length, 0x0C read index (read-only, so writes to it are ignored), 0x10 write index, 0x14 interrupt status, 0x18 base low word, 0x1C base high word.
- R3: The ring base address is `ADDR_W` (48) bits wide. Bits written at 0x1C above bit `ADDR_W-33` are dropped, and they read back as zero.
- R4: While the read index equals the write index, no descriptor fetch is requested.
- R5: A fetch request carries address `base + 32*read_index`. `fetch_valid` and `fetch_addr` stay stable until `fetch_ready` is sampled high. The descriptor returned on `rsp_data` is presented unchanged on `exec_desc` while `exec_valid` is high.
- R6: At most one descriptor is in flight. No new fetch is requested until the writeback of the current descriptor has been accepted.
- R7: After `exec_done`, the controller requests a writeback at `base + 32*read_index + 4`. The data is `{16'h0, err, status}`, where status is 8'h03 when `exec_err` is zero and 8'h04 otherwise. `wb_valid` and `wb_addr` stay stable until `wb_ready` is sampled high.
- R8: Each accepted writeback moves the read index up by one, and the read index wraps to 0 when it reaches the ring length.
- R9: Each completed descriptor sets bit 0 of the interrupt status, and `irq` follows that bit. A write to 0x14 with bit 0 at zero clears it. A write with bit 0 at one leaves it unchanged.
- R10: When the ring length is zero, no fetch is requested, even if the two indices differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe; data valid the next cycle |
| reg_addr | input | REG_AW | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| fetch_valid | output | 1 | Descriptor read request valid |
| fetch_ready | input | 1 | Descriptor read request accepted |
| fetch_addr | output | ADDR_W | Descriptor byte address |
| rsp_valid | input | 1 | Descriptor data returned |
| rsp_data | input | DESC_W | Descriptor contents |
| exec_valid | output | 1 | Descriptor presented to copy stage |
| exec_desc | output | DESC_W | Descriptor for copy stage |
| exec_done | input | 1 | Copy stage finished |
| exec_err | input | 8 | Copy stage error code, zero on success |
| wb_valid | output | 1 | Status writeback request valid |
| wb_ready | input | 1 | Status writeback accepted |
| wb_addr | output | ADDR_W | Writeback byte address |
| wb_data | output | 32 | Writeback status word |
| irq | output | 1 | Level completion interrupt |

## Verification
A read index that is wrong shows up two ways: in the `fetch_addr` of the very next request, and in the value read at 0x0C one cycle after the writeback handshake. A wrap error therefore shows up on the fetch that follows the last ring slot. An interrupt bit that was set or cleared wrongly reaches `irq` on the edge after the completion or the status write. A sequencer that left its state early would raise a second fetch while a descriptor is still executing, and the bench watches for exactly that during a deliberately stalled copy.

// File: rtl/rq_pkg.sv
`timescale 1ns/1ps
package rq_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE, SQ_FETCH, SQ_WAIT, SQ_EXEC, SQ_WB
  } seq_state_t;

  localparam logic [4:0] OFS_LEN  = 5'h08;
  localparam logic [4:0] OFS_RIDX = 5'h0C;
  localparam logic [4:0] OFS_WIDX = 5'h10;
  localparam logic [4:0] OFS_IST  = 5'h14;
  localparam logic [4:0] OFS_BLO  = 5'h18;
  localparam logic [4:0] OFS_BHI  = 5'h1C;

  localparam logic [7:0] ST_DONE = 8'h03;
  localparam logic [7:0] ST_FAIL = 8'h04;
endpackage

// File: rtl/rq_regs.sv
`timescale 1ns/1ps
module rq_regs #(
  parameter int QUEUE_ID = 0,
  parameter int REG_AW   = 12,
  parameter int ADDR_W   = 48,
  parameter int IDX_W    = 8,
  parameter int LEN_W    = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic              done_i,
  output logic [LEN_W-1:0]  ring_len_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [ADDR_W-1:0] base_o,
  output logic              irq_o
);
  import rq_pkg::*;

  localparam int HI_W = ADDR_W - 32;
  localparam logic [REG_AW-6:0] WIN = (REG_AW-5)'(QUEUE_ID + 1);

  logic       hit;
  logic [4:0] ofs;
  logic [31:0] rmux;

  assign hit = (addr[REG_AW-1:5] == WIN);
  assign ofs = addr[4:0];

  always_comb begin
    case (ofs)
      OFS_LEN:  rmux = 32'(ring_len_o);
      OFS_RIDX: rmux = 32'(rd_idx_i);
      OFS_WIDX: rmux = 32'(wr_idx_o);
      OFS_IST:  rmux = {31'h0, irq_o};
      OFS_BLO:  rmux = base_o[31:0];
      OFS_BHI:  rmux = 32'(base_o[ADDR_W-1:32]);
      default:  rmux = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ring_len_o <= '0;
      wr_idx_o   <= '0;
      base_o     <= '0;
      irq_o      <= 1'b0;
      rdata      <= '0;
    end else begin
      if (wr_en && hit) begin
        case (ofs)
          OFS_LEN:  ring_len_o <= wdata[LEN_W-1:0];
          OFS_WIDX: wr_idx_o   <= wdata[IDX_W-1:0];
          OFS_IST:  if (!wdata[0]) irq_o <= 1'b0;
          OFS_BLO:  base_o[31:0] <= wdata;
          OFS_BHI:  base_o[ADDR_W-1:32] <= wdata[HI_W-1:0];
          default: ;
        endcase
      end
      if (done_i) irq_o <= 1'b1;
      rdata <= (rd_en && hit) ? rmux : 32'h0;
    end
  end

  // R9: a completion always leaves the status bit set on the next edge
  a_r9_set_on_done: assert property (@(posedge clk) disable iff (rst)
    done_i |=> irq_o);
endmodule

// File: rtl/rq_ring_ptr.sv
`timescale 1ns/1ps
module rq_ring_ptr #(
  parameter int IDX_W = 8,
  parameter int LEN_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [IDX_W-1:0] rd_o
);
  logic [LEN_W-1:0] nxt;

  assign nxt = LEN_W'(rd_o) + LEN_W'(1);

  always_ff @(posedge clk) begin
    if (rst)        rd_o <= '0;
    else if (adv_i) rd_o <= (nxt >= len_i) ? '0 : nxt[IDX_W-1:0];
  end

  // R8: the read index moves only on an accepted writeback
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !adv_i |=> $stable(rd_o));
endmodule

// File: rtl/rq_sequencer.sv
`timescale 1ns/1ps
module rq_sequencer #(
  parameter int ADDR_W     = 48,
  parameter int IDX_W      = 8,
  parameter int LEN_W      = 9,
  parameter int DESC_W     = 256,
  parameter int DESC_BYTES = 32,
  parameter int STAT_OFS   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              fetch_valid,
  input  logic              fetch_ready,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic              rsp_valid,
  input  logic [DESC_W-1:0] rsp_data,
  output logic              exec_valid,
  output logic [DESC_W-1:0] exec_desc,
  input  logic              exec_done,
  input  logic [7:0]        exec_err,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [31:0]       wb_data,
  output logic              adv_o,
  output logic              done_o
);
  import rq_pkg::*;

  localparam int SH = $clog2(DESC_BYTES);

  seq_state_t state;

  assign fetch_valid = (state == SQ_FETCH);
  assign exec_valid  = (state == SQ_EXEC);
  assign wb_valid    = (state == SQ_WB);
  assign adv_o       = wb_valid && wb_ready;
  assign done_o      = adv_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SQ_IDLE;
      fetch_addr <= '0;
      wb_addr    <= '0;
      exec_desc  <= '0;
      wb_data    <= '0;
    end else begin
      case (state)
        SQ_IDLE: if (len_i != '0 && rd_idx_i != wr_idx_i) begin
          fetch_addr <= base_i + (ADDR_W'(rd_idx_i) << SH);
          state      <= SQ_FETCH;
        end
        SQ_FETCH: if (fetch_ready) begin
          wb_addr <= fetch_addr + ADDR_W'(STAT_OFS);
          state   <= SQ_WAIT;
        end
        SQ_WAIT: if (rsp_valid) begin
          exec_desc <= rsp_data;
          state     <= SQ_EXEC;
        end
        SQ_EXEC: if (exec_done) begin
          wb_data <= {16'h0, exec_err, (exec_err == 8'h0) ? ST_DONE : ST_FAIL};
          state   <= SQ_WB;
        end
        SQ_WB: if (wb_ready) state <= SQ_IDLE;
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // R5: fetch request held until accepted
  a_r5_fetch_hold: assert property (@(posedge clk) disable iff (rst)
    fetch_valid && !fetch_ready |=> fetch_valid && $stable(fetch_addr));

  // R7: writeback request held until accepted
  a_r7_wb_hold: assert property (@(posedge clk) disable iff (rst)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr) && $stable(wb_data));
endmodule

// File: rtl/ring_queue_ctrl.sv
`timescale 1ns/1ps
module ring_queue_ctrl #(
  parameter int QUEUE_ID   = 2,
  parameter int REG_AW     = 12,
  parameter int ADDR_W     = 48,
  parameter int RING_MAX   = 256,
  parameter int DESC_BYTES = 32,
  parameter int DESC_W     = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              fetch_valid,
  input  logic              fetch_ready,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic              rsp_valid,
  input  logic [DESC_W-1:0] rsp_data,
  output logic              exec_valid,
  output logic [DESC_W-1:0] exec_desc,
  input  logic              exec_done,
  input  logic [7:0]        exec_err,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [31:0]       wb_data,
  output logic              irq
);
  localparam int IDX_W = $clog2(RING_MAX);
  localparam int LEN_W = IDX_W + 1;

  logic [IDX_W-1:0]  rd_idx, wr_idx;
  logic [LEN_W-1:0]  ring_len;
  logic [ADDR_W-1:0] base;
  logic              adv, done;

  rq_regs #(.QUEUE_ID(QUEUE_ID), .REG_AW(REG_AW), .ADDR_W(ADDR_W),
            .IDX_W(IDX_W), .LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .rd_en(reg_rd_en),
    .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .rd_idx_i(rd_idx), .done_i(done), .ring_len_o(ring_len),
    .wr_idx_o(wr_idx), .base_o(base), .irq_o(irq));

  rq_ring_ptr #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_ptr (
    .clk(clk), .rst(rst), .adv_i(adv), .len_i(ring_len), .rd_o(rd_idx));

  rq_sequencer #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .LEN_W(LEN_W),
                 .DESC_W(DESC_W), .DESC_BYTES(DESC_BYTES), .STAT_OFS(4)) u_seq (
    .clk(clk), .rst(rst), .rd_idx_i(rd_idx), .wr_idx_i(wr_idx),
    .len_i(ring_len), .base_i(base),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_addr(fetch_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .exec_valid(exec_valid), .exec_desc(exec_desc),
    .exec_done(exec_done), .exec_err(exec_err),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_data(wb_data),
    .adv_o(adv), .done_o(done));

  // R4 / R10: a fetch starts only from a non-empty ring of non-zero length
  a_r4_fetch_nonempty: assert property (@(posedge clk) disable iff (rst)
    $rose(fetch_valid) |-> $past(rd_idx != wr_idx && ring_len != '0));
endmodule

// File: tb/tb_ring_queue_ctrl.sv
`timescale 1ns/1ps
module tb_ring_queue_ctrl;
  localparam int AW = 12;
  localparam int XW = 48;
  localparam int DW = 256;
  localparam logic [AW-1:0] WB  = 12'h060;
  localparam logic [AW-1:0] A_LEN = WB + 12'h08, A_RIDX = WB + 12'h0C,
    A_WIDX = WB + 12'h10, A_IST = WB + 12'h14, A_BLO = WB + 12'h18, A_BHI = WB + 12'h1C;
  localparam logic [XW-1:0] BASE = 48'h1234_5678_0000;

  localparam int NV = 6;
  localparam logic [7:0] V_ERR [NV]   = '{8'h00, 8'h00, 8'h05, 8'h00, 8'h01, 8'h00};
  localparam int         V_STALL [NV] = '{0, 2, 0, 1, 0, 3};
  localparam logic [7:0] V_STAT [NV]  = '{8'h03, 8'h03, 8'h04, 8'h03, 8'h04, 8'h03};

  logic clk = 0, rst = 1;
  logic reg_wr_en = 0, reg_rd_en = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic fetch_valid, fetch_ready = 0;
  logic [XW-1:0] fetch_addr, wb_addr;
  logic rsp_valid = 0;
  logic [DW-1:0] rsp_data = '0, exec_desc;
  logic exec_valid, exec_done = 0;
  logic [7:0] exec_err = '0;
  logic wb_valid, wb_ready = 0, irq;
  logic [31:0] wb_data;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  ring_queue_ctrl #(.QUEUE_ID(2), .REG_AW(AW), .ADDR_W(XW), .RING_MAX(256),
                    .DESC_BYTES(32), .DESC_W(DW)) dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr_en = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr_en = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd_en = 1; reg_addr = a;
    @(negedge clk); reg_rd_en = 0; d = reg_rdata;
  endtask

  task automatic wait_hi(ref logic s);
    for (int k = 0; k < 60 && !s; k++) @(negedge clk);
  endtask

  // Serve one descriptor as memory and copy stage
  task automatic serve(input int idx, input logic [7:0] err, input int stall,
                       input logic [7:0] stat, input bit check_single);
    logic [DW-1:0] pat;
    logic [XW-1:0] ea;
    pat = {8{32'hC0DE_0000 + 32'(idx)}};
    ea  = BASE + XW'(idx) * 32;
    wait_hi(fetch_valid);
    chk("R5 fetch valid", 64'(fetch_valid), 64'd1);
    chk("R5 fetch addr", 64'(fetch_addr), 64'(ea));
    for (int s = 0; s < stall; s++) @(negedge clk);
    chk("R5 held addr", {63'h0, fetch_valid} ^ 64'(fetch_addr), {63'h0, 1'b1} ^ 64'(ea));
    fetch_ready = 1; @(negedge clk); fetch_ready = 0;
    rsp_valid = 1; rsp_data = pat; @(negedge clk); rsp_valid = 0;
    wait_hi(exec_valid);
    chk("R5 desc pass", 64'(exec_desc == pat), 64'd1);
    if (check_single) begin
      for (int s = 0; s < 5; s++) begin
        @(negedge clk);
        chk("R6 no second fetch", 64'(fetch_valid), 64'd0);
      end
    end
    exec_err = err; exec_done = 1; @(negedge clk); exec_done = 0;
    wait_hi(wb_valid);
    chk("R7 wb addr", 64'(wb_addr), 64'(ea + 4));
    chk("R7 wb data", 64'(wb_data), 64'({16'h0, err, stat}));
    if (check_single) chk("R6 no fetch in wb", 64'(fetch_valid), 64'd0);
    wb_ready = 1; @(negedge clk); wb_ready = 0;
    chk("R9 irq set", 64'(irq), 64'd1);
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", 64'(irq), 0);
    chk("R1 fetch", 64'(fetch_valid | exec_valid | wb_valid), 0);
    rd(A_LEN, d);  chk("R1 len", 64'(d), 0);
    rd(A_RIDX, d); chk("R1 ridx", 64'(d), 0);
    rd(A_WIDX, d); chk("R1 widx", 64'(d), 0);
    rd(A_IST, d);  chk("R1 ist", 64'(d), 0);
    // R2 window decode
    wr(12'h028, 32'd7);
    rd(A_LEN, d);  chk("R2 other window write ignored", 64'(d), 0);
    wr(A_LEN, 32'd3);
    rd(12'h028, d); chk("R2 other window read zero", 64'(d), 0);
    wr(A_RIDX, 32'd3);
    rd(A_RIDX, d); chk("R2 ridx read-only", 64'(d), 0);
    wr(A_LEN, 32'd0);
    // R3 base address
    wr(A_BLO, BASE[31:0]);
    wr(A_BHI, 32'hABCD_1234);
    rd(A_BHI, d); chk("R3 base hi truncated", 64'(d), 64'h1234);
    rd(A_BLO, d); chk("R3 base lo", 64'(d), 64'h5678_0000);
    // R10 zero length
    wr(A_WIDX, 32'd1);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); chk("R10 no fetch len0", 64'(fetch_valid), 0);
    end
    wr(A_WIDX, 32'd0);
    // R4 empty ring
    wr(A_LEN, 32'd4);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); chk("R4 no fetch empty", 64'(fetch_valid), 0);
    end
    // Vector table: one descriptor per entry, ring of 4 wraps
    for (int i = 0; i < NV; i++) begin
      wr(A_WIDX, 32'((i + 1) % 4));
      serve(i % 4, V_ERR[i], V_STALL[i], V_STAT[i], 0);
      rd(A_RIDX, d); chk("R8 ridx advance/wrap", 64'(d), 64'((i + 1) % 4));
      wr(A_IST, 32'hFFFF_FFFE);
      chk("R9 irq cleared", 64'(irq), 0);
    end
    // R6 two pending, one at a time (rd now 2)
    wr(A_WIDX, 32'd0);
    serve(2, 8'h00, 0, 8'h03, 1);
    // R9 writing bit0=1 has no effect
    wr(A_IST, 32'h1);
    chk("R9 write one keeps irq", 64'(irq), 1);
    rd(A_IST, d); chk("R9 ist reads set", 64'(d), 1);
    serve(3, 8'h00, 0, 8'h03, 1);
    rd(A_RIDX, d); chk("R8 wrap to zero", 64'(d), 0);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); chk("R4 idle after drain", 64'(fetch_valid), 0);
    end
    wr(A_IST, 32'h0);
    chk("R9 irq cleared end", 64'(irq), 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule